// File: doc/BRIEF.md
# Daisy-Chained Interrupt Grant Chain

This block holds the per-device logic for a run of devices that share one priority level of a bus request line and one daisy-chained grant line. Each node takes its device's service request, raises the shared bus request, and watches the grant as it ripples from the processor side toward the far end of the chain. A node with an outstanding request stops the grant there. A node with no request lets it through without delay. The requesting node nearest the processor therefore wins.

The winning node becomes bus master. It drives its own service-routine start address onto the 18-bit word-address bus, where the processor picks it up as the new program counter and begins an instruction fetch. The node keeps that address on the bus for one transfer phase. When the processor acknowledges, the node releases the bus and drops its request. Each node's start address is a parameter. Addresses count 16-bit words.

Top module: `irq_grant_chain`

## Requirements
- R1: After reset every node is idle. bus_req_o, bus_busy_o and master_o are 0, vec_addr_o is 0, and grant_o follows grant_i.
- R2: If dev_req_i[k] is high at a clock edge while node k is idle and the grant reaching node k is low, node k becomes pending. bus_req_o is high whenever at least one node is pending.
- R3: A node that is idle passes the grant it receives to the next node in the same cycle, with no register in the path.
- R4: A pending or mastering node blocks the grant from every node after it. Node 0 is nearest the processor, so the lowest-index pending node wins. grant_o is 1 only when no node is pending or mastering.
- R5: A pending node that sees its incoming grant high at a clock edge becomes master from the next cycle. master_o is a one-hot code with bit k set for node k, and bus_busy_o is high. A node never becomes master while its incoming grant is low.
- R6: A request raised while the grant is already high at a node's input is not latched, so the chain is not cut partway. If the request is still high after the grant falls, it is latched at the next edge.
- R7: A master holds the bus until ack_i is sampled high at a clock edge. From the next cycle it is idle: master_o bit k, bus_busy_o and its request are cleared.
- R8: While node k is master, changes on dev_req_i[k] have no effect. If the request is still high after release, the node becomes pending again one edge later.
- R9: vec_addr_o carries the 18-bit word address parameter of the mastering node: 18'h00040, 18'h00100, 18'h00200 and 18'h00300 for nodes 0 to 3 by default. It is 0 when no node is master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | NODES | Service request from each device |
| grant_i | input | 1 | Grant arriving from the processor side |
| ack_i | input | 1 | Processor acknowledge that ends the address phase |
| grant_o | output | 1 | Grant leaving the far end of the chain |
| bus_req_o | output | 1 | Shared bus request, high while any node is pending |
| bus_busy_o | output | 1 | High while any node is bus master |
| master_o | output | NODES | One-hot flag of the mastering node |
| vec_addr_o | output | ADDR_W | Service-routine word address driven by the master |

## Verification
A node stuck idle after its device requests shows up as bus_req_o low on the very next cycle. A node wrongly left pending or mastering shows up at once on grant_o, because it stays low while grant_i is high. A wrong start-address parameter, or a master that does not clear, shows up on vec_addr_o and master_o in the cycle after the grant edge or the acknowledge edge. The table walk covers each winner position so that every slice of the address merge and every chain link is observed.

// File: rtl/irq_grant_pkg.sv
package irq_grant_pkg;
  localparam int unsigned ADDR_W = 18;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PEND   = 2'd1,
    ST_MASTER = 2'd2
  } node_st_e;
endpackage

// File: rtl/irq_grant_node.sv
module irq_grant_node
  import irq_grant_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 18,
  parameter logic [ADDR_W-1:0] VEC_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              grant_i,
  output logic              grant_o,
  output logic              pend_o,
  output logic              master_o,
  output logic [ADDR_W-1:0] vec_o
);
  node_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      // latch only while grant is absent so the chain is never cut mid-pass
      ST_IDLE:   if (req_i && !grant_i) st_d = ST_PEND;
      ST_PEND:   if (grant_i)           st_d = ST_MASTER;
      ST_MASTER: if (ack_i)             st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign grant_o  = grant_i && (st_q == ST_IDLE);
  assign pend_o   = (st_q == ST_PEND);
  assign master_o = (st_q == ST_MASTER);
  assign vec_o    = master_o ? VEC_ADDR : '0;
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int unsigned NODES  = 4,
  parameter int unsigned ADDR_W = 18
) (
  input  logic [NODES-1:0][ADDR_W-1:0] vec_i,
  output logic [ADDR_W-1:0]            vec_o
);
  // at most one master drives a non-zero value
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NODES; i++) vec_o |= vec_i[i];
  end
endmodule

// File: rtl/irq_grant_chain.sv
module irq_grant_chain
  import irq_grant_pkg::*;
#(
  parameter int unsigned                   NODES     = 4,
  parameter int unsigned                   ADDR_W    = irq_grant_pkg::ADDR_W,
  parameter logic [NODES-1:0][ADDR_W-1:0] VEC_TABLE = {18'h00300, 18'h00200, 18'h00100, 18'h00040}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NODES-1:0]  dev_req_i,
  input  logic              grant_i,
  input  logic              ack_i,
  output logic              grant_o,
  output logic              bus_req_o,
  output logic              bus_busy_o,
  output logic [NODES-1:0]  master_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic [NODES:0]                 chain;
  logic [NODES-1:0]               pend;
  logic [NODES-1:0][ADDR_W-1:0]   vec;

  assign chain[0] = grant_i;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    irq_grant_node #(
      .ADDR_W   (ADDR_W),
      .VEC_ADDR (VEC_TABLE[g])
    ) u_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (dev_req_i[g]),
      .ack_i    (ack_i),
      .grant_i  (chain[g]),
      .grant_o  (chain[g+1]),
      .pend_o   (pend[g]),
      .master_o (master_o[g]),
      .vec_o    (vec[g])
    );
  end

  irq_vec_merge #(
    .NODES  (NODES),
    .ADDR_W (ADDR_W)
  ) u_merge (
    .vec_i (vec),
    .vec_o (vec_addr_o)
  );

  assign grant_o    = chain[NODES];
  assign bus_req_o  = |pend;
  assign bus_busy_o = |master_o;
endmodule

// File: rtl/irq_grant_chain_chk.sv
module irq_grant_chain_chk #(
  parameter int unsigned NODES  = 4,
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              grant_i,
  input logic              ack_i,
  input logic              grant_o,
  input logic              bus_req_o,
  input logic [NODES-1:0]  master_o,
  input logic [ADDR_W-1:0] vec_addr_o
);
  p_onehot_master_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(master_o));

  p_master_needs_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o == '0 && !grant_i) |=> master_o == '0);

  p_grant_out_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (!bus_req_o && master_o == '0));

  p_no_mid_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !bus_req_o && master_o == '0) |=> (!grant_i || !bus_req_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o != '0 && ack_i) |=> master_o == '0);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o != '0 && !ack_i) |=> $stable(master_o));

  p_vec_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o == '0) |-> vec_addr_o == '0);
endmodule

bind irq_grant_chain irq_grant_chain_chk #(
  .NODES  (NODES),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grant_i    (grant_i),
  .ack_i      (ack_i),
  .grant_o    (grant_o),
  .bus_req_o  (bus_req_o),
  .master_o   (master_o),
  .vec_addr_o (vec_addr_o)
);

// File: tb/irq_grant_chain_tb_top.sv
module irq_grant_chain_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NODES      = 4;
  localparam int  ADDR_W     = 18;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NODES-1:0]  dev_req_i = '0;
  logic              grant_i = 1'b0;
  logic              ack_i = 1'b0;
  logic              grant_o, bus_req_o, bus_busy_o;
  logic [NODES-1:0]  master_o;
  logic [ADDR_W-1:0] vec_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_grant_chain dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_req_i  (dev_req_i),
    .grant_i    (grant_i),
    .ack_i      (ack_i),
    .grant_o    (grant_o),
    .bus_req_o  (bus_req_o),
    .bus_busy_o (bus_busy_o),
    .master_o   (master_o),
    .vec_addr_o (vec_addr_o)
  );

  // {req[3:0], exp_grant_o, exp_master[3:0], exp_vec[17:0]}
  localparam logic [26:0] VECS [6] = '{
    {4'b0001, 1'b0, 4'b0001, 18'h00040},
    {4'b0110, 1'b0, 4'b0010, 18'h00100},
    {4'b1100, 1'b0, 4'b0100, 18'h00200},
    {4'b1000, 1'b0, 4'b1000, 18'h00300},
    {4'b1111, 1'b0, 4'b0001, 18'h00040},
    {4'b0000, 1'b1, 4'b0000, 18'h00000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; dev_req_i = '0; grant_i = 1'b0; ack_i = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 bus_req", 32'(bus_req_o), 0);
    chk("R1 busy", 32'(bus_busy_o), 0);
    chk("R1 master", 32'(master_o), 0);
    chk("R1 vec", 32'(vec_addr_o), 0);
    grant_i = 1'b1; #1;
    chk("R1 grant follows", 32'(grant_o), 1);
    grant_i = 1'b0; #1;
    chk("R1 grant follows low", 32'(grant_o), 0);

    // table walk: R2 latch, R3/R4 pass/absorb, R5/R9 master+vector, R7 release
    foreach (VECS[i]) begin
      do_reset();
      dev_req_i = VECS[i][26:23];
      tick();
      dev_req_i = '0; #1;
      chk("R2 bus_req", 32'(bus_req_o), 32'(|VECS[i][26:23]));
      grant_i = 1'b1; #1;
      chk("R3_R4 grant_o", 32'(grant_o), 32'(VECS[i][22]));
      tick();
      chk("R5 master", 32'(master_o), 32'(VECS[i][21:18]));
      chk("R5 busy", 32'(bus_busy_o), 32'(|VECS[i][21:18]));
      chk("R9 vec", 32'(vec_addr_o), 32'(VECS[i][17:0]));
      grant_i = 1'b0; ack_i = 1'b1;
      tick();
      ack_i = 1'b0; #1;
      chk("R7 master cleared", 32'(master_o), 0);
      chk("R9 vec idle", 32'(vec_addr_o), 0);
    end

    // R6: request raised while grant passing is not latched
    do_reset();
    grant_i = 1'b1;
    dev_req_i = 4'b0100; #1;
    chk("R6 grant passes", 32'(grant_o), 1);
    tick();
    chk("R6 no latch", 32'(bus_req_o), 0);
    chk("R6 still passes", 32'(grant_o), 1);
    chk("R6 no master", 32'(master_o), 0);
    grant_i = 1'b0;
    tick();
    chk("R6 latched later", 32'(bus_req_o), 1);
    grant_i = 1'b1; #1;
    chk("R6 absorbs now", 32'(grant_o), 0);
    tick();
    chk("R6 master", 32'(master_o), 32'(4'b0100));
    chk("R6 vec", 32'(vec_addr_o), 32'(18'h00200));

    // R7 hold without ack, R8 request changes ignored while master
    do_reset();
    dev_req_i = 4'b0001;
    tick();
    grant_i = 1'b1;
    tick();
    grant_i = 1'b0;
    dev_req_i = 4'b0000;
    tick();
    chk("R8 ignore drop", 32'(master_o), 32'(4'b0001));
    chk("R7 hold bus_req low", 32'(bus_req_o), 0);
    dev_req_i = 4'b0001;
    tick();
    chk("R8 ignore raise", 32'(master_o), 32'(4'b0001));
    chk("R8 no pend while master", 32'(bus_req_o), 0);
    chk("R7 vec held", 32'(vec_addr_o), 32'(18'h00040));
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0; #1;
    chk("R7 released", 32'(bus_busy_o), 0);
    chk("R7 request cleared", 32'(bus_req_o), 0);
    tick();
    chk("R8 repend", 32'(bus_req_o), 1);

    finish_run();
  end
endmodule